// File: doc/BRIEF.md
# Label-Swap Route Lookup Stage

This stage sits at the input of a switch and decides where each arriving packet header goes. The low bits of the header hold a label that is used as an address into a small local routing table. The table entry at that address names the output port for this switch. It also holds the label the next switch will need. The stage emits the chosen port beside the header and writes the new label into the header's label field, so the downstream switch can make its own lookup. A controller fills and changes the table through a separate write port.

Headers enter and leave on valid/ready streams. One register stage sits between them, so the output port is known one cycle after a header is accepted. A small controller with two states tracks that register:

- `ST_EMPTY`: no header is held.
- `ST_FULL`: a header is presented at the output.

The controller has four transitions:

- `T_FILL` (`ST_EMPTY` to `ST_FULL`): a header is accepted.
- `T_STREAM` (`ST_FULL` to `ST_FULL`): the output is taken and a new header is accepted in the same cycle.
- `T_STALL` (`ST_FULL` to `ST_FULL`): the output is not taken, and the held header stays.
- `T_DRAIN` (`ST_FULL` to `ST_EMPTY`): the output is taken and no new header arrives.

If an entry has not been made valid, the header is sent to a fixed discard port and is flagged.

Top module: `lswap_route_top`

## Requirements
- R1: A header accepted at a clock edge (`hin_valid` and `hin_ready` both high) appears on `hout_*` with `hout_valid` high right after that edge. While `hout_ready` stays high, one header is accepted every cycle.
- R2: For a valid entry, `hout_port` equals the port field of the table entry addressed by the low `IDX_W` bits of the accepted header.
- R3: For a valid entry, the low `IDX_W` bits of `hout_hdr` equal the entry's next-label field. The upper `HDR_W-IDX_W` bits are passed through unchanged.
- R4: A lookup of an entry whose valid bit is clear drives `hout_err` to 1 and `hout_port` to `DISCARD_PORT` (default 7). The header leaves unchanged. For valid entries `hout_err` is 0.
- R5: While `hout_valid` is high and `hout_ready` is low, `hout_hdr`, `hout_port` and `hout_err` keep their values and `hin_ready` is low, so no new header is taken.
- R6: When a table write and a lookup address the same entry at the same edge, the lookup uses the old contents. The new contents are used by lookups from the next edge on.
- R7: After reset, `hout_valid` is 0, `hin_ready` is 1, and every table entry is invalid.
- R8: A table write with `tw_valid` = 0 makes that entry invalid, so later lookups of it follow R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| hin_valid | input | 1 | Header input valid |
| hin_ready | output | 1 | Header input can be taken |
| hin_hdr | input | HDR_W | Header in; low IDX_W bits are the label |
| hout_valid | output | 1 | Header output valid |
| hout_ready | input | 1 | Downstream takes the output |
| hout_hdr | output | HDR_W | Header with the label rewritten |
| hout_port | output | PORT_W | Output port chosen for this switch |
| hout_err | output | 1 | Lookup hit an invalid entry |
| tw_en | input | 1 | Table write strobe |
| tw_addr | input | IDX_W | Entry to write |
| tw_port | input | PORT_W | Output port field to store |
| tw_next | input | IDX_W | Next-label field to store |
| tw_valid | input | 1 | Valid bit to store |

## Verification
Two events can land on the same clock edge: a table write and a header lookup of the same entry. The bench creates this by raising `tw_en` for entry 2 in the same half-cycle that it presents a header addressing entry 2. It then expects the output to carry the entry's previous port and label. A second header to entry 2 on the following cycle must show the newly written values. A second overlap, a stalled output meeting a new header, is created by holding `hout_ready` low. It is judged by the stable output and a low `hin_ready`.

// File: rtl/lswap_pkg.sv
package lswap_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } lk_state_e;

endpackage

// File: rtl/lswap_table.sv
module lswap_table #(
    parameter int DEPTH  = 16,
    parameter int PORT_W = 3,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [IDX_W-1:0]  wr_next,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic              rd_valid,
    output logic [PORT_W-1:0] rd_port,
    output logic [IDX_W-1:0]  rd_next
);

    logic [DEPTH-1:0]  ent_vld;
    logic [PORT_W-1:0] ent_port [DEPTH];
    logic [IDX_W-1:0]  ent_next [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[e]  <= 1'b0;
                ent_port[e] <= '0;
                ent_next[e] <= '0;
            end else if (wr_en && (wr_addr == IDX_W'(e))) begin
                ent_vld[e]  <= wr_valid;
                ent_port[e] <= wr_port;
                ent_next[e] <= wr_next;
            end
        end
    end

    // Read sees the registered contents, so a write at the same edge is not yet visible.
    always_comb begin
        rd_valid = ent_vld[rd_addr];
        rd_port  = ent_port[rd_addr];
        rd_next  = ent_next[rd_addr];
    end

    // R6 / R8: a write lands in the addressed entry on the following edge
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_vld[$past(wr_addr)] == $past(wr_valid)) &&
                  (ent_port[$past(wr_addr)] == $past(wr_port)) &&
                  (ent_next[$past(wr_addr)] == $past(wr_next)));

endmodule

// File: rtl/lswap_rewrite.sv
module lswap_rewrite #(
    parameter int HDR_W        = 12,
    parameter int IDX_W        = 4,
    parameter int PORT_W       = 3,
    parameter int DISCARD_PORT = 7
) (
    input  logic [HDR_W-1:0]  hdr_in,
    input  logic              ent_valid,
    input  logic [PORT_W-1:0] ent_port,
    input  logic [IDX_W-1:0]  ent_next,
    output logic [HDR_W-1:0]  hdr_new,
    output logic [PORT_W-1:0] port_sel,
    output logic              miss
);

    localparam int KEEP_W = HDR_W - IDX_W;

    always_comb begin
        miss = !ent_valid;
        if (ent_valid) begin
            hdr_new  = {hdr_in[HDR_W-1:IDX_W], ent_next};
            port_sel = ent_port;
        end else begin
            hdr_new  = hdr_in;
            port_sel = PORT_W'(DISCARD_PORT);
        end
    end

    initial begin
        assert (KEEP_W >= 0) else $error("header narrower than label");
    end

endmodule

// File: rtl/lswap_ctl.sv
module lswap_ctl
    import lswap_pkg::*;
#(
    parameter int HDR_W        = 12,
    parameter int PORT_W       = 3,
    parameter int DISCARD_PORT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HDR_W-1:0]  nx_hdr,
    input  logic [PORT_W-1:0] nx_port,
    input  logic              nx_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [HDR_W-1:0]  out_hdr,
    output logic [PORT_W-1:0] out_port,
    output logic              out_err
);

    lk_state_e state_q, state_d;
    logic      take;

    assign in_ready  = (state_q == ST_EMPTY) || out_ready;
    assign take      = in_valid && in_ready;
    assign out_valid = (state_q == ST_FULL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (take) state_d = ST_FULL;              // T_FILL
            ST_FULL:  if (out_ready && !take) state_d = ST_EMPTY; // T_DRAIN
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_hdr  <= '0;
            out_port <= '0;
            out_err  <= 1'b0;
        end else if (take) begin
            out_hdr  <= nx_hdr;
            out_port <= nx_port;
            out_err  <= nx_err;
        end
    end

    // R1: an accepted header is presented after the edge
    p_accept_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R5: a stalled output keeps every field
    p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_hdr) &&
                                      $stable(out_port) && $stable(out_err));

    // R4: a flagged miss always leaves on the discard port
    p_miss_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_port == PORT_W'(DISCARD_PORT)));

endmodule

// File: rtl/lswap_route_top.sv
module lswap_route_top #(
    parameter int TBL_DEPTH    = 16,
    parameter int PORT_W       = 3,
    parameter int HDR_W        = 12,
    parameter int DISCARD_PORT = 7,
    parameter int IDX_W        = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hin_valid,
    output logic              hin_ready,
    input  logic [HDR_W-1:0]  hin_hdr,
    output logic              hout_valid,
    input  logic              hout_ready,
    output logic [HDR_W-1:0]  hout_hdr,
    output logic [PORT_W-1:0] hout_port,
    output logic              hout_err,
    input  logic              tw_en,
    input  logic [IDX_W-1:0]  tw_addr,
    input  logic [PORT_W-1:0] tw_port,
    input  logic [IDX_W-1:0]  tw_next,
    input  logic              tw_valid
);

    logic              ent_valid;
    logic [PORT_W-1:0] ent_port;
    logic [IDX_W-1:0]  ent_next;
    logic [HDR_W-1:0]  nx_hdr;
    logic [PORT_W-1:0] nx_port;
    logic              nx_err;

    lswap_table #(.DEPTH(TBL_DEPTH), .PORT_W(PORT_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tw_en), .wr_addr(tw_addr), .wr_port(tw_port),
        .wr_next(tw_next), .wr_valid(tw_valid),
        .rd_addr(hin_hdr[IDX_W-1:0]),
        .rd_valid(ent_valid), .rd_port(ent_port), .rd_next(ent_next)
    );

    lswap_rewrite #(.HDR_W(HDR_W), .IDX_W(IDX_W), .PORT_W(PORT_W),
                    .DISCARD_PORT(DISCARD_PORT)) u_rewrite (
        .hdr_in(hin_hdr), .ent_valid(ent_valid), .ent_port(ent_port),
        .ent_next(ent_next), .hdr_new(nx_hdr), .port_sel(nx_port), .miss(nx_err)
    );

    lswap_ctl #(.HDR_W(HDR_W), .PORT_W(PORT_W), .DISCARD_PORT(DISCARD_PORT)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(hin_valid), .in_ready(hin_ready),
        .nx_hdr(nx_hdr), .nx_port(nx_port), .nx_err(nx_err),
        .out_valid(hout_valid), .out_ready(hout_ready),
        .out_hdr(hout_hdr), .out_port(hout_port), .out_err(hout_err)
    );

endmodule

// File: tb/lswap_route_tb.sv
`timescale 1ns/1ps
module lswap_route_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hin_valid = 1'b0;
    logic        hin_ready;
    logic [11:0] hin_hdr = '0;
    logic        hout_valid;
    logic        hout_ready = 1'b1;
    logic [11:0] hout_hdr;
    logic [2:0]  hout_port;
    logic        hout_err;
    logic        tw_en = 1'b0;
    logic [3:0]  tw_addr = '0;
    logic [2:0]  tw_port = '0;
    logic [3:0]  tw_next = '0;
    logic        tw_valid = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    lswap_route_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .hin_valid(hin_valid), .hin_ready(hin_ready), .hin_hdr(hin_hdr),
        .hout_valid(hout_valid), .hout_ready(hout_ready), .hout_hdr(hout_hdr),
        .hout_port(hout_port), .hout_err(hout_err),
        .tw_en(tw_en), .tw_addr(tw_addr), .tw_port(tw_port),
        .tw_next(tw_next), .tw_valid(tw_valid)
    );

    // vector: {hdr_in[12], port[3], err[1], hdr_out[12]}
    localparam int NV = 8;
    localparam logic [27:0] VEC [NV] = '{
        {12'hA30, 3'd0, 1'b0, 12'hA37},
        {12'h5B1, 3'd3, 1'b0, 12'h5B8},
        {12'h0F5, 3'd7, 1'b1, 12'h0F5},
        {12'hC37, 3'd5, 1'b0, 12'hC3E},
        {12'h12F, 3'd5, 1'b0, 12'h126},
        {12'hFFC, 3'd7, 1'b1, 12'hFFC},
        {12'h77A, 3'd6, 1'b0, 12'h771},
        {12'h003, 3'd1, 1'b0, 12'h00A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic twrite(input int a, input int p, input int nx, input logic v);
        @(negedge clk);
        tw_en = 1'b1; tw_addr = 4'(a); tw_port = 3'(p); tw_next = 4'(nx); tw_valid = v;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 hout_valid after reset", 32'(hout_valid), 0);
        chk("R7 hin_ready after reset", 32'(hin_ready), 1);

        // R7: table empty after reset -> discard
        hin_valid = 1'b1; hin_hdr = 12'h009;
        @(negedge clk);
        hin_valid = 1'b0;
        chk("R7 miss after reset err", 32'(hout_err), 1);
        chk("R7 miss after reset port", 32'(hout_port), 7);

        // program table: port=(i*3)%8, next=(i+7)%16, entries 5 and 12 invalid
        for (int i = 0; i < 16; i++)
            twrite(i, (i * 3) % 8, (i + 7) % 16, (i != 5) && (i != 12));

        // vector walk, back to back (R1..R4)
        for (int k = 0; k <= NV; k++) begin
            @(negedge clk);
            if (k > 0) begin
                chk("R1 valid", 32'(hout_valid), 1);
                chk("R2 port", 32'(hout_port), 32'(VEC[k-1][15:13]));
                chk("R4 err", 32'(hout_err), 32'(VEC[k-1][12]));
                chk("R3 hdr", 32'(hout_hdr), 32'(VEC[k-1][11:0]));
            end
            if (k < NV) begin
                hin_valid = 1'b1; hin_hdr = VEC[k][27:16];
            end else hin_valid = 1'b0;
        end

        // R5: backpressure
        @(negedge clk);
        hout_ready = 1'b0; hin_valid = 1'b1; hin_hdr = 12'h0B3;
        @(negedge clk);
        chk("R1 stall entry hdr", 32'(hout_hdr), 32'h0BA);
        hin_hdr = 12'h0D0;
        chk("R5 hin_ready low", 32'(hin_ready), 0);
        repeat (2) @(negedge clk);
        chk("R5 held hdr", 32'(hout_hdr), 32'h0BA);
        chk("R5 held port", 32'(hout_port), 1);
        chk("R5 still blocked", 32'(hin_ready), 0);
        hout_ready = 1'b1;
        @(negedge clk);
        hin_valid = 1'b0;
        chk("R5 after release hdr", 32'(hout_hdr), 32'h0D7);
        chk("R5 after release port", 32'(hout_port), 0);
        @(negedge clk);
        chk("R1 drained", 32'(hout_valid), 0);

        // R6: write and lookup of entry 2 at the same edge (old: port 6, next 9)
        @(negedge clk);
        tw_en = 1'b1; tw_addr = 4'd2; tw_port = 3'd2; tw_next = 4'd4; tw_valid = 1'b1;
        hin_valid = 1'b1; hin_hdr = 12'h402;
        @(negedge clk);
        tw_en = 1'b0;
        chk("R6 same-edge old hdr", 32'(hout_hdr), 32'h409);
        chk("R6 same-edge old port", 32'(hout_port), 6);
        @(negedge clk);
        hin_valid = 1'b0;
        chk("R6 next-edge new hdr", 32'(hout_hdr), 32'h404);
        chk("R6 next-edge new port", 32'(hout_port), 2);

        // R8: invalidate entry 1
        twrite(1, 3, 8, 1'b0);
        @(negedge clk);
        hin_valid = 1'b1; hin_hdr = 12'h001;
        @(negedge clk);
        hin_valid = 1'b0;
        chk("R8 invalidated err", 32'(hout_err), 1);
        chk("R8 invalidated port", 32'(hout_port), 7);
        chk("R8 invalidated hdr", 32'(hout_hdr), 32'h001);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule